// File: doc/BRIEF.md
# Serial Converter Command Front End

This block is the digital front end of a 13-bit digital-to-analog converter. A host drives a serial clock, a data line and an active-low chip select. While chip select is low, the block shifts in one 16-bit word per frame, most significant bit first. The top three bits are an operation code and the lower thirteen are a data word. When chip select is released, the word is decoded and acted on, but only if the frame held exactly sixteen clock pulses.

The operations can load a staging register, move the staged value into the active converter code, drive a general-purpose output pin, pick the serial-clock edge on which the echo output changes, or put the block to sleep and wake it. The shift register is echoed on the serial output so that several parts can be chained and the host can read the data back. An active-low clear input zeroes both code registers at once, with no clock needed. The serial pins are oversampled by the block's own clock through a synchronizer, so the serial clock must be much slower than the system clock.

Top module: `dacfe_top`

## Requirements
- R1: Frame bit 15 arrives first. Bits 15:13 are the operation code and bits 12:0 are the data. Code 001 stores the data in the staging register and leaves `dac_code` unchanged. Code 011 then copies the staging register to `dac_code`.
- R2: Code 010 stores the data in the staging register and puts it on `dac_code` in the same step.
- R3: A frame that has fewer or more than 16 rising serial-clock edges while chip select is low changes no register.
- R4: A frame sent as two 8-bit bursts, with an idle gap in between and chip select held low, is accepted like a continuous frame.
- R5: After code 101, `dout` changes on each rising serial-clock edge. Its new value is the shift-register MSB after the shift, so it lags `din` by 15.5 clock periods.
- R6: After reset, and after code 100, `dout` changes on each falling serial-clock edge to the shift-register MSB, so it lags `din` by 16 clock periods.
- R7: Code 110 sets `user_pin` to data bit 12.
- R8: Code 111 with data bit 12 = 1 sets `sleep`. With data bit 12 = 0 it clears `sleep`.
- R9: While `sleep` is 1, `dout` does not change and code 110 has no effect on `user_pin`.
- R10: Driving `clr_n` low forces `dac_code` and the staging register to zero without waiting for a clock edge.
- R11: If `clr_n` was low while asleep, `user_pin` goes to 0 on wake-up. Otherwise it keeps its level through sleep and wake.
- R12: Code 000 changes no output and no register.
- R13: After reset, `dac_code` is 0, `user_pin` is 0, `sleep` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of the code registers |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data in, MSB first |
| dout | output | 1 | Serial echo of the shift register |
| user_pin | output | 1 | General-purpose output pin |
| dac_code | output | 13 | Active converter code |
| sleep | output | 1 | Power-down state flag |

## Verification
The load path is tried with patterns that separate its cases: a stage-only load followed by a separate update, which shows whether the two registers are independent; combined load-and-update words at all-ones and all-zeros; and a frame split into two bytes with a long pause. Frames of 15 and 17 pulses show whether the pulse count is checked exactly and not as a minimum. The echo line is checked on every bit of every frame in the high phase of the serial clock. In that phase, falling-edge mode still shows the older bit and rising-edge mode already shows the next one, so the edge selection and its half-cycle lag difference are both visible. Sleep sequences are run with and without a clear, which shows that a pin write is blocked while asleep and that the pin returns to its default only when a clear occurred.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    parameter int CTRL_W  = 3;
    parameter int DATA_W  = 13;
    localparam int FRAME_W = CTRL_W + DATA_W;

    typedef enum logic [CTRL_W-1:0] {
        OP_NOP      = 3'b000,
        OP_STAGE    = 3'b001,
        OP_STAGE_GO = 3'b010,
        OP_COMMIT   = 3'b011,
        OP_EDGE_LO  = 3'b100,
        OP_EDGE_HI  = 3'b101,
        OP_PIN      = 3'b110,
        OP_SLEEP    = 3'b111
    } op_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } echo_edge_e;

    typedef struct packed {
        op_e               op;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic frame_t to_frame(input logic [FRAME_W-1:0] raw);
        return frame_t'(raw);
    endfunction

    function automatic logic flag_bit(input frame_t f);
        return f.data[DATA_W-1];
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_s,
    input  logic               cs_n_s,
    input  logic               din_s,
    input  logic               hold_echo,
    input  echo_edge_e         edge_sel,
    output logic               dout,
    output logic               frm_valid,
    output logic [FRAME_W-1:0] frm_word
);

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    logic               sclk_q, cs_q;
    logic               sck_rise, sck_fall, cs_rise, cs_fall, active;
    logic [FRAME_W-1:0] sr, sr_next;
    logic [CNT_W-1:0]   cnt;

    assign sck_rise = sclk_s & ~sclk_q;
    assign sck_fall = ~sclk_s & sclk_q;
    assign cs_rise  = cs_n_s & ~cs_q;
    assign cs_fall  = ~cs_n_s & cs_q;
    assign active   = ~cs_n_s;
    assign sr_next  = {sr[FRAME_W-2:0], din_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            sr        <= '0;
            cnt       <= '0;
            dout      <= 1'b0;
            frm_valid <= 1'b0;
        end else begin
            sclk_q    <= sclk_s;
            cs_q      <= cs_n_s;
            frm_valid <= cs_rise && (cnt == CNT_FULL);
            if (cs_fall) begin
                cnt <= '0;
            end else if (active && sck_rise) begin
                sr <= sr_next;
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
            if (!hold_echo && active) begin
                if (edge_sel == EDGE_RISE && sck_rise)
                    dout <= sr_next[FRAME_W-1];
                else if (edge_sel == EDGE_FALL && sck_fall)
                    dout <= sr[FRAME_W-1];
            end
        end
    end

    assign frm_word = sr;

endmodule

// File: rtl/dacfe_exec.sv
module dacfe_exec
    import dacfe_pkg::*;
#(
    parameter logic PIN_DEFAULT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              clr_n_s,
    input  logic              frm_valid,
    input  frame_t            frm,
    output logic [DATA_W-1:0] dac_code,
    output logic              user_pin,
    output logic              sleep,
    output echo_edge_e        edge_sel
);

    logic [DATA_W-1:0] stage_q;
    logic              clr_pending;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stage_q  <= '0;
            dac_code <= '0;
        end else if (rst) begin
            stage_q  <= '0;
            dac_code <= '0;
        end else if (frm_valid) begin
            case (frm.op)
                OP_STAGE:    stage_q <= frm.data;
                OP_STAGE_GO: begin
                    stage_q  <= frm.data;
                    dac_code <= frm.data;
                end
                OP_COMMIT:   dac_code <= stage_q;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            user_pin    <= PIN_DEFAULT;
            sleep       <= 1'b0;
            edge_sel    <= EDGE_FALL;
            clr_pending <= 1'b0;
        end else begin
            if (!clr_n_s && sleep) clr_pending <= 1'b1;
            if (frm_valid) begin
                case (frm.op)
                    OP_EDGE_LO: edge_sel <= EDGE_FALL;
                    OP_EDGE_HI: edge_sel <= EDGE_RISE;
                    OP_PIN: begin
                        if (!sleep) user_pin <= flag_bit(frm);
                    end
                    OP_SLEEP: begin
                        if (flag_bit(frm)) begin
                            sleep <= 1'b1;
                        end else begin
                            if (sleep && (clr_pending || !clr_n_s))
                                user_pin <= PIN_DEFAULT;
                            sleep       <= 1'b0;
                            clr_pending <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic PIN_DEFAULT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    output logic              dout,
    output logic              user_pin,
    output logic [DATA_W-1:0] dac_code,
    output logic              sleep
);

    localparam int PIN_W = 4;

    logic [PIN_W-1:0]   pins_s;
    logic               frm_valid;
    logic [FRAME_W-1:0] frm_word;
    echo_edge_e         edge_sel;

    dacfe_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({clr_n, cs_n, sclk, din}),
        .q   (pins_s)
    );

    dacfe_shifter shift_i (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[1]),
        .cs_n_s    (pins_s[2]),
        .din_s     (pins_s[0]),
        .hold_echo (sleep),
        .edge_sel  (edge_sel),
        .dout      (dout),
        .frm_valid (frm_valid),
        .frm_word  (frm_word)
    );

    dacfe_exec #(
        .PIN_DEFAULT (PIN_DEFAULT)
    ) exec_i (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .clr_n_s   (pins_s[3]),
        .frm_valid (frm_valid),
        .frm       (to_frame(frm_word)),
        .dac_code  (dac_code),
        .user_pin  (user_pin),
        .sleep     (sleep),
        .edge_sel  (edge_sel)
    );

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clr_n,
    input logic              dout,
    input logic              user_pin,
    input logic              sleep,
    input logic [DATA_W-1:0] dac_code,
    input logic              frm_valid,
    input logic              edge_sel
);

    p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dac_code == '0));

    p_code_source_r2: assert property (@(posedge clk) disable iff (rst)
        (dac_code != $past(dac_code)) |-> ($past(frm_valid) || !clr_n || !$past(clr_n)));

    p_echo_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (sleep && $past(sleep)) |-> $stable(dout));

    p_pin_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (sleep && $past(sleep)) |-> $stable(user_pin));

    p_edge_by_frame_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(edge_sel) |-> $past(frm_valid));

    p_sleep_by_frame_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sleep) |-> $past(frm_valid));

endmodule

bind dacfe_top dacfe_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .dout      (dout),
    .user_pin  (user_pin),
    .sleep     (sleep),
    .dac_code  (dac_code),
    .frm_valid (frm_valid),
    .edge_sel  (edge_sel)
);

// File: tb/dacfe_top_tb_top.sv
module dacfe_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        dout, user_pin, sleep;
    logic [12:0] dac_code;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] hist = '0;
    logic        exp_dout = 1'b0;
    logic        exp_mode = 1'b0;
    logic        exp_pd = 1'b0;
    logic        exp_pin = 1'b0;
    logic        pending = 1'b0;
    logic [12:0] exp_stage = '0;
    logic [12:0] exp_dac = '0;

    always #2.5 clk = ~clk;

    dacfe_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .clr_n    (clr_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .din      (din),
        .dout     (dout),
        .user_pin (user_pin),
        .dac_code (dac_code),
        .sleep    (sleep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply_model(input logic [15:0] w);
        logic [2:0]  op;
        logic [12:0] d;
        op = w[15:13];
        d  = w[12:0];
        case (op)
            3'b001: exp_stage = d;
            3'b010: begin exp_stage = d; exp_dac = d; end
            3'b011: exp_dac = exp_stage;
            3'b100: exp_mode = 1'b0;
            3'b101: exp_mode = 1'b1;
            3'b110: if (!exp_pd) exp_pin = d[12];
            3'b111: begin
                if (d[12]) exp_pd = 1'b1;
                else begin
                    if (exp_pd && pending) exp_pin = 1'b0;
                    exp_pd = 1'b0;
                    pending = 1'b0;
                end
            end
            default: ;
        endcase
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " dac_code"}, 32'(dac_code), 32'(exp_dac));
        chk({tag, " user_pin"}, 32'(user_pin), 32'(exp_pin));
        chk({tag, " sleep"}, 32'(sleep), 32'(exp_pd));
    endtask

    task automatic send(input string tag, input logic [15:0] w, input int nb, input bit split);
        cs_n = 1'b0;
        #50;
        for (int i = 0; i < nb; i++) begin
            logic b;
            b = (i < 16) ? w[15-i] : 1'b0;
            din = b;
            #50;
            sclk = 1'b1;
            hist = {hist[14:0], b};
            if (!exp_pd && exp_mode) exp_dout = hist[15];
            #40;
            chk(exp_pd ? "R9 dout frozen" : (exp_mode ? "R5 dout rise" : "R6 dout fall"),
                32'(dout), 32'(exp_dout));
            #10;
            sclk = 1'b0;
            if (!exp_pd && !exp_mode) exp_dout = hist[15];
            if (split && i == 7) #400;
        end
        #50;
        cs_n = 1'b1;
        #100;
        if (nb == 16) apply_model(w);
        check_outputs(tag);
    endtask

    task automatic clear_pulse();
        clr_n = 1'b0;
        #1;
        chk("R10 async clear", 32'(dac_code), 32'd0);
        exp_stage = '0;
        exp_dac = '0;
        if (exp_pd) pending = 1'b1;
        #30;
        clr_n = 1'b1;
        #30;
        check_outputs("R10 after clear");
    endtask

    task automatic t_reset();
        chk("R13 reset dac_code", 32'(dac_code), 32'd0);
        chk("R13 reset user_pin", 32'(user_pin), 32'd0);
        chk("R13 reset sleep", 32'(sleep), 32'd0);
        chk("R13 reset dout", 32'(dout), 32'd0);
    endtask

    task automatic t_load_update();
        send("R1 stage only", {3'b001, 13'h1ABC}, 16, 1'b0);
        send("R1 commit", {3'b011, 13'h0000}, 16, 1'b0);
        send("R2 stage and go", {3'b010, 13'h0555}, 16, 1'b0);
        send("R2 all ones", {3'b010, 13'h1FFF}, 16, 1'b0);
        send("R2 all zeros", {3'b010, 13'h0000}, 16, 1'b0);
    endtask

    task automatic t_bad_count();
        send("R3 15 pulses", {3'b010, 13'h0AAA}, 15, 1'b0);
        send("R3 17 pulses", {3'b010, 13'h0AAA}, 17, 1'b0);
        send("R3 valid after", {3'b010, 13'h0333}, 16, 1'b0);
    endtask

    task automatic t_split();
        send("R4 two bytes", {3'b010, 13'h1234}, 16, 1'b1);
    endtask

    task automatic t_modes();
        send("R5 to rise mode", {3'b101, 13'h0F0F}, 16, 1'b0);
        send("R5 echo rise", {3'b010, 13'h1A5A}, 16, 1'b0);
        send("R5 echo rise", {3'b001, 13'h0C3C}, 16, 1'b0);
        send("R6 to fall mode", {3'b100, 13'h1111}, 16, 1'b0);
        send("R6 echo fall", {3'b010, 13'h0999}, 16, 1'b0);
    endtask

    task automatic t_pin();
        send("R7 pin high", {3'b110, 13'h1000}, 16, 1'b0);
        send("R7 pin low", {3'b110, 13'h0FFF}, 16, 1'b0);
        send("R7 pin high again", {3'b110, 13'h1000}, 16, 1'b0);
    endtask

    task automatic t_sleep();
        send("R8 enter sleep", {3'b111, 13'h1000}, 16, 1'b0);
        send("R9 pin write ignored", {3'b110, 13'h0000}, 16, 1'b0);
        send("R8 wake", {3'b111, 13'h0000}, 16, 1'b0);
        chk("R11 pin kept without clear", 32'(user_pin), 32'd1);
        send("R5 rise mode", {3'b101, 13'h0000}, 16, 1'b0);
        send("R8 sleep again", {3'b111, 13'h1FFF}, 16, 1'b0);
        clear_pulse();
        send("R11 wake after clear", {3'b111, 13'h0FFF}, 16, 1'b0);
        chk("R11 pin default", 32'(user_pin), 32'd0);
        send("R6 back to fall", {3'b100, 13'h0000}, 16, 1'b0);
    endtask

    task automatic t_clear();
        send("R10 preload", {3'b010, 13'h0F0F}, 16, 1'b0);
        clear_pulse();
        send("R10 commit zero stage", {3'b011, 13'h1555}, 16, 1'b0);
        chk("R10 stage cleared", 32'(dac_code), 32'd0);
    endtask

    task automatic t_nop();
        send("R12 setup", {3'b010, 13'h0777}, 16, 1'b0);
        send("R12 no-op", {3'b000, 13'h1FFF}, 16, 1'b0);
        chk("R12 code kept", 32'(dac_code), 32'h0777);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        #50;
        rst = 1'b0;
        #50;
        t_reset();
        t_load_update();
        t_bad_count();
        t_split();
        t_modes();
        t_pin();
        t_sleep();
        t_clear();
        t_nop();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule